// File: doc/BRIEF.md
# Hamming (7,4) Single-Error-Correcting Codec

This block pairs a systematic (7,4) Hamming encoder with a syndrome decoder. The encoder takes a 4-bit data nibble. It returns a 7-bit codeword: the four data bits sit in the upper positions and three check bits follow them. The decoder takes a 7-bit word that may hold one flipped bit. It evaluates three parity checks, and the pattern of failed checks points at the bit in error. The decoder then flips that bit and returns the repaired nibble.

Besides the data, the decoder gives three more outputs: an error flag, the position of the bit it repaired, and a flag that says whether that bit was a data bit or a check bit. Both cores are pure logic. The parameter `OUT_REG` places an optional register stage on all outputs.

Bit numbering: word bit k (0..6) is position k+1. Bits 6..3 hold data bits 3..0. Bits 2, 1 and 0 are the three check bits.

Top module: `hamming74_codec`

## Requirements
- R1: With `OUT_REG`=1 and `rst_n` low, every output is zero, whatever the inputs are.
- R2: `enc_word[6:3]` equals `enc_data`. The check bits are computed as follows:
  - `enc_word[2] = d3^d1^d0`
  - `enc_word[1] = d3^d2^d0`
  - `enc_word[0] = d3^d2^d1`
- R3: When all three checks pass, the decoder reports no error:
  - The three checks are `w6^w4^w3^w2`, `w6^w5^w3^w1` and `w6^w5^w4^w0`.
  - `dec_err` is 0, `dec_pos` is 0 and `dec_data` equals `dec_word[6:3]`.
- R4: A valid codeword with exactly one bit flipped gives `dec_err`=1. `dec_data` then equals the original data nibble.
- R5: For a single flip of word bit k, `dec_pos` is k+1. The check pattern (first, second, third) maps to a position as follows: 111→7, 011→6, 101→5, 110→4, 100→3, 010→2, 001→1.
- R6: `dec_pos_is_data` is 1 when `dec_pos` is 4..7 (a data bit was repaired). It is 0 when the repair hit a check bit or when there is no error.
- R7: With `OUT_REG`=1, outputs change only at the rising clock edge after the inputs change. They show the result one clock later.
- R8: Any two codewords from distinct data nibbles differ in at least 3 bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| enc_data | input | 4 | Data nibble to encode |
| enc_word | output | 7 | Systematic codeword, data in bits 6..3 |
| dec_word | input | 7 | Received word to check and repair |
| dec_data | output | 4 | Repaired data nibble |
| dec_err | output | 1 | A single-bit error was found and repaired |
| dec_pos | output | 3 | Position 1..7 of the repaired bit, 0 if none |
| dec_pos_is_data | output | 1 | The repaired bit was a data bit |

## Verification
The assertions check four properties every cycle:
- Every encoder output satisfies all three decoder checks.
- A word with a clean syndrome passes through untouched.
- A repair changes exactly one bit, and the repaired word is a valid codeword.
- The returned data differs from the received data bits only when the data-bit flag is set.

Three behaviours need the bench's scenarios, which drive known data and known flips:
- whether the repair restores the original nibble,
- whether the reported position matches the bit that was actually flipped,
- the one-clock latency, the reset values, and the distance-3 property of the whole code.

// File: rtl/hamming74_codec.sv
module hamming74_codec #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] enc_data,
  output logic [6:0] enc_word,
  input  logic [6:0] dec_word,
  output logic [3:0] dec_data,
  output logic       dec_err,
  output logic [2:0] dec_pos,
  output logic       dec_pos_is_data
);
  localparam int DW = 4;
  localparam int CW = 7;
  localparam int PW = $clog2(CW + 1);

  logic [CW-1:0] enc_c;
  logic [2:0]    syn;
  logic [PW-1:0] pos_c;
  logic [CW-1:0] flip;
  logic [CW-1:0] fixed;
  logic [DW-1:0] data_c;
  logic          err_c;
  logic          kind_c;

  assign enc_c = {enc_data,
                  enc_data[3] ^ enc_data[1] ^ enc_data[0],
                  enc_data[3] ^ enc_data[2] ^ enc_data[0],
                  enc_data[3] ^ enc_data[2] ^ enc_data[1]};

  assign syn = {dec_word[6] ^ dec_word[4] ^ dec_word[3] ^ dec_word[2],
                dec_word[6] ^ dec_word[5] ^ dec_word[3] ^ dec_word[1],
                dec_word[6] ^ dec_word[5] ^ dec_word[4] ^ dec_word[0]};

  always_comb begin
    case (syn)
      3'b111:  pos_c = 3'd7;
      3'b011:  pos_c = 3'd6;
      3'b101:  pos_c = 3'd5;
      3'b110:  pos_c = 3'd4;
      3'b100:  pos_c = 3'd3;
      3'b010:  pos_c = 3'd2;
      3'b001:  pos_c = 3'd1;
      default: pos_c = 3'd0;
    endcase
  end

  always_comb begin
    flip = '0;
    if (pos_c != '0) flip[pos_c - 3'd1] = 1'b1;
  end

  assign fixed  = dec_word ^ flip;
  assign data_c = fixed[CW-1:CW-DW];
  assign err_c  = |syn;
  assign kind_c = pos_c[PW-1];

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          enc_word        <= '0;
          dec_data        <= '0;
          dec_err         <= 1'b0;
          dec_pos         <= '0;
          dec_pos_is_data <= 1'b0;
        end else begin
          enc_word        <= enc_c;
          dec_data        <= data_c;
          dec_err         <= err_c;
          dec_pos         <= pos_c;
          dec_pos_is_data <= kind_c;
        end
      end
    end else begin : g_comb
      assign enc_word        = enc_c;
      assign dec_data        = data_c;
      assign dec_err         = err_c;
      assign dec_pos         = pos_c;
      assign dec_pos_is_data = kind_c;
    end
  endgenerate

  // R2: every codeword the encoder emits passes all three decoder checks
  a_r2_enc_is_codeword: assert property (@(posedge clk) disable iff (!rst_n)
    ((enc_c[6] ^ enc_c[4] ^ enc_c[3] ^ enc_c[2]) == 1'b0) &&
    ((enc_c[6] ^ enc_c[5] ^ enc_c[3] ^ enc_c[1]) == 1'b0) &&
    ((enc_c[6] ^ enc_c[5] ^ enc_c[4] ^ enc_c[0]) == 1'b0));

  a_r3_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (syn == 3'b000) |-> (!err_c && pos_c == '0 && data_c == dec_word[6:3]));

  a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    err_c |-> ($countones(fixed ^ dec_word) == 1));

  a_r4_repair_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_c |-> (((fixed[6] ^ fixed[4] ^ fixed[3] ^ fixed[2]) == 1'b0) &&
               ((fixed[6] ^ fixed[5] ^ fixed[3] ^ fixed[1]) == 1'b0) &&
               ((fixed[6] ^ fixed[5] ^ fixed[4] ^ fixed[0]) == 1'b0)));

  a_r6_parity_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    !kind_c |-> (data_c == dec_word[6:3]));

  a_r6_data_repair: assert property (@(posedge clk) disable iff (!rst_n)
    kind_c |-> (data_c != dec_word[6:3]));
endmodule

// File: tb/test_hamming74_codec.sv
module test_hamming74_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] enc_data = 4'hA;
  logic [6:0] dec_word = 7'h55;
  logic [6:0] enc_word;
  logic [3:0] dec_data;
  logic       dec_err;
  logic [2:0] dec_pos;
  logic       dec_pos_is_data;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hamming74_codec #(.OUT_REG(1'b1)) i_hamming74_codec (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_word(enc_word),
    .dec_word(dec_word), .dec_data(dec_data), .dec_err(dec_err),
    .dec_pos(dec_pos), .dec_pos_is_data(dec_pos_is_data));

  function automatic logic [6:0] ref_code(input logic [3:0] d);
    return {d, d[3]^d[1]^d[0], d[3]^d[2]^d[0], d[3]^d[2]^d[1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic [6:0] w);
    @(negedge clk);
    enc_data = d;
    dec_word = w;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 enc_word", enc_word, 0);
    chk("R1 dec_data", dec_data, 0);
    chk("R1 dec_err", dec_err, 0);
    chk("R1 dec_pos", dec_pos, 0);
    chk("R1 dec_pos_is_data", dec_pos_is_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_encode_all;
    for (int d = 0; d < 16; d++) begin
      apply(d[3:0], 7'h00);
      chk("R2 codeword", enc_word, ref_code(d[3:0]));
    end
  endtask

  task automatic t_clean_decode;
    for (int d = 0; d < 16; d++) begin
      apply(4'h0, ref_code(d[3:0]));
      chk("R3 data", dec_data, d);
      chk("R3 err", dec_err, 0);
      chk("R3 pos", dec_pos, 0);
      chk("R6 flag clean", dec_pos_is_data, 0);
    end
  endtask

  task automatic t_single_errors;
    for (int d = 0; d < 16; d++)
      for (int k = 0; k < 7; k++) begin
        apply(4'h0, ref_code(d[3:0]) ^ (7'd1 << k));
        chk("R4 err", dec_err, 1);
        chk("R4 data", dec_data, d);
        chk("R5 pos", dec_pos, k + 1);
        chk("R6 flag", dec_pos_is_data, (k >= 3) ? 1 : 0);
      end
  endtask

  task automatic t_latency;
    apply(4'h3, ref_code(4'h9));
    @(negedge clk);
    enc_data = 4'hC;
    dec_word = ref_code(4'h6) ^ 7'h40;
    #2;
    chk("R7 enc held", enc_word, ref_code(4'h3));
    chk("R7 err held", dec_err, 0);
    chk("R7 data held", dec_data, 4'h9);
    @(negedge clk);
    chk("R7 enc next", enc_word, ref_code(4'hC));
    chk("R7 err next", dec_err, 1);
    chk("R7 pos next", dec_pos, 7);
    chk("R7 data next", dec_data, 4'h6);
  endtask

  task automatic t_distance;
    int mind = 7;
    logic [6:0] a, b;
    for (int x = 0; x < 16; x++) begin
      apply(x[3:0], 7'h00);
      a = enc_word;
      for (int y = 0; y < 16; y++)
        if (y != x) begin
          apply(y[3:0], 7'h00);
          b = enc_word;
          if ($countones(a ^ b) < mind) mind = $countones(a ^ b);
        end
    end
    chk("R8 min distance", (mind >= 3) ? 1 : 0, 1);
  endtask

  initial begin
    t_reset();
    t_encode_all();
    t_clean_decode();
    t_single_errors();
    t_latency();
    t_distance();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule